// File: doc/BRIEF.md
# Synthesizer Configuration Loader

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback count M, a 2-bit post-divide code N and a 3-bit test selector T. Two ports can write these settings. A parallel port carries M and N on wide inputs and has a level-sensitive strobe. While that strobe is low the settings follow the inputs, and its rising edge freezes them. A three-wire serial port clocks bits into a 14-bit shift register. A serial strobe then copies the register into the settings. The copy is transparent while that strobe is high and holds from its falling edge.

The parallel port always wins. A serial transfer has an effect only while the parallel strobe is high. While the parallel strobe is low, T is held at zero, and the parallel port has no way to set T. All asynchronous pins are sampled by one fast system clock through two-stage synchronisers. Edges are detected in the synchronised domain, so the design has no real latches. The top of the shift register is brought out as a serial output bit.

Top module: `synth_cfg_loader`

## Requirements
- R1: Each rising edge of the serial clock shifts the 14-bit register once. The synchronised data bit enters at bit 0. `ser_out` is bit 13, which is the bit shifted in 13 edges earlier.
- R2: After 14 shifts the first bit sent lands in bit 13. The field layout is: bits 13..11 carry T (T2 sent first), bits 10..9 carry N (N1 first), and bits 8..0 carry M (M8 first).
- R3: While the parallel strobe is low, M and N follow `par_m` and `par_n`. The strobe's rising edge keeps the last values seen while it was low. After that edge, changes on `par_m` and `par_n` have no effect.
- R4: While the parallel strobe is low, T reads 000. The parallel port never sets T.
- R5: With the parallel strobe high and the serial strobe high, M, N and T follow the shift register. When the serial strobe falls, they keep their last value.
- R6: While the parallel strobe is low, pulses on the serial strobe have no effect on M, N or T.
- R7: With the parallel strobe high and the serial strobe low, M, N and T hold their value, even while bits are being shifted.
- R8: A change on any input pin reaches the outputs on the third system clock edge after it is applied: two synchroniser stages, then the output register.
- R9: Reset clears M, N, T and the shift register to zero, so `ser_out` reads 0.
- R10: A serial clock held high for many system cycles shifts the register exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every pin it samples |
| rst | input | 1 | Synchronous active-high reset |
| par_strobe | input | 1 | Parallel load strobe; low means transparent, rising edge captures |
| par_m | input | 9 | Parallel feedback count |
| par_n | input | 2 | Parallel post-divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial load strobe; high means transparent, falling edge holds |
| m_out | output | 9 | Current feedback count |
| n_out | output | 2 | Current post-divide code |
| t_out | output | 3 | Current test selector |
| ser_out | output | 1 | Top bit of the shift register |

## Verification
A bad bit in the shift register shows on `ser_out` within the number of serial shifts needed to carry it to the top. It also shows on the settings as soon as a serial strobe opens the copy path. A wrong source choice in the holding logic shows at the ports on the third clock after the strobe change. It appears as T not dropping to zero, parallel values leaking through after capture, or serial values overriding the parallel port. A bench model advances on every system clock and is compared with all four outputs. Errors are therefore caught in the first cycle they become visible, not only at the end of a transfer.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int SR_W = T_W + N_W + M_W;
    localparam int PAR_W = N_W + M_W;

    // Field order equals shift-register layout: first bit sent ends up on top.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic [1:0] {
        SRC_PARALLEL = 2'd0,
        SRC_SERIAL   = 2'd1,
        SRC_HOLD     = 2'd2
    } cfg_src_t;

    localparam cfg_word_t CFG_RESET = '{t: '0, n: '0, m: '0};

    function automatic cfg_word_t word_to_cfg(input logic [SR_W-1:0] w);
        return cfg_word_t'(w);
    endfunction

    function automatic cfg_word_t par_to_cfg(input logic [N_W-1:0] n,
                                             input logic [M_W-1:0] m);
        cfg_word_t c;
        c.t = '0;
        c.n = n;
        c.m = m;
        return c;
    endfunction

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter
    import synth_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_s,
    input  logic            sdata_s,
    output logic [SR_W-1:0] sr
);
    logic sclk_prev;
    logic shift_en;

    assign shift_en = sclk_s & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            sr        <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (shift_en) sr <= {sr[SR_W-2:0], sdata_s};
        end
    end
endmodule

// File: rtl/synth_cfg_holder.sv
module synth_cfg_holder
    import synth_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            par_strobe_s,
    input  logic            ser_strobe_s,
    input  logic [N_W-1:0]  par_n_s,
    input  logic [M_W-1:0]  par_m_s,
    input  logic [SR_W-1:0] sr,
    output cfg_word_t       cfg
);
    cfg_src_t  src;
    cfg_word_t nxt;

    always_comb begin
        if (!par_strobe_s)     src = SRC_PARALLEL;
        else if (ser_strobe_s) src = SRC_SERIAL;
        else                   src = SRC_HOLD;

        case (src)
            SRC_PARALLEL: nxt = par_to_cfg(par_n_s, par_m_s);
            SRC_SERIAL:   nxt = word_to_cfg(sr);
            default:      nxt = cfg;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= CFG_RESET;
        else     cfg <= nxt;
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           par_strobe,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_strobe,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic [T_W-1:0] t_out,
    output logic           ser_out
);
    localparam int CTL_W = 4;

    logic [CTL_W-1:0] ctl_s;
    logic [PAR_W-1:0] par_s;
    logic             ps_s, ss_s, sclk_s, sd_s;
    logic [N_W-1:0]   pn_s;
    logic [M_W-1:0]   pm_s;
    logic [SR_W-1:0]  sr;
    cfg_word_t        cfg;

    synth_cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   ({par_strobe, ser_strobe, ser_clk, ser_data}),
        .q   (ctl_s)
    );

    synth_cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES)) u_sync_par (
        .clk (clk),
        .rst (rst),
        .d   ({par_n, par_m}),
        .q   (par_s)
    );

    assign {ps_s, ss_s, sclk_s, sd_s} = ctl_s;
    assign {pn_s, pm_s}               = par_s;

    synth_cfg_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .sdata_s (sd_s),
        .sr      (sr)
    );

    synth_cfg_holder u_hold (
        .clk          (clk),
        .rst          (rst),
        .par_strobe_s (ps_s),
        .ser_strobe_s (ss_s),
        .par_n_s      (pn_s),
        .par_m_s      (pm_s),
        .sr           (sr),
        .cfg          (cfg)
    );

    assign m_out   = cfg.m;
    assign n_out   = cfg.n;
    assign t_out   = cfg.t;
    assign ser_out = sr[SR_W-1];
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
    import synth_cfg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ps_s,
    input logic            ss_s,
    input logic            sclk_s,
    input logic            sd_s,
    input logic [N_W-1:0]  pn_s,
    input logic [M_W-1:0]  pm_s,
    input logic [SR_W-1:0] sr,
    input logic [M_W-1:0]  m_out,
    input logic [N_W-1:0]  n_out,
    input logic [T_W-1:0]  t_out
);
    p_shift_once_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_s) |=> (sr == {$past(sr[SR_W-2:0]), $past(sd_s)}));

    p_no_shift_r10: assert property (@(posedge clk) disable iff (rst)
        !$rose(sclk_s) |=> $stable(sr));

    p_par_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !ps_s |=> (m_out == $past(pm_s) && n_out == $past(pn_s)));

    p_test_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !ps_s |=> (t_out == '0));

    p_ser_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (ps_s && ss_s) |=> ({t_out, n_out, m_out} == $past(sr)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ps_s && !ss_s) |=> ($stable(m_out) && $stable(n_out) && $stable(t_out)));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ps_s   (ps_s),
    .ss_s   (ss_s),
    .sclk_s (sclk_s),
    .sd_s   (sd_s),
    .pn_s   (pn_s),
    .pm_s   (pm_s),
    .sr     (sr),
    .m_out  (m_out),
    .n_out  (n_out),
    .t_out  (t_out)
);

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_strobe = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_strobe = 1'b0;
    logic [8:0] m_out;
    logic [1:0] n_out;
    logic [2:0] t_out;
    logic       ser_out;

    int checks = 0;
    int errors = 0;
    string phase = "R9";

    always #5 clk = ~clk;

    synth_cfg_loader u0 (
        .clk(clk), .rst(rst), .par_strobe(par_strobe), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .m_out(m_out), .n_out(n_out),
        .t_out(t_out), .ser_out(ser_out)
    );

    // Reference model: pin samples travel through a history queue, then rules apply.
    logic [14:0] hq[$];
    logic [13:0] msr;
    logic [8:0]  mm;
    logic [1:0]  mn;
    logic [2:0]  mt;

    always @(posedge clk) begin
        logic [14:0] cur, prv, now;
        now = {par_strobe, ser_strobe, ser_clk, ser_data, par_n, par_m};
        if (rst) begin
            hq = {15'd0, 15'd0, 15'd0};
            msr = '0; mm = '0; mn = '0; mt = '0;
        end else begin
            prv = hq[0];
            cur = hq[1];
            if (!cur[14])     {mt, mn, mm} = {3'b000, cur[10:0]};
            else if (cur[13]) {mt, mn, mm} = msr;
            if (cur[12] && !prv[12]) msr = {msr[12:0], cur[11]};
            void'(hq.pop_front());
            hq.push_back(now);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (m_out !== mm || n_out !== mn || t_out !== mt || ser_out !== msr[13]) begin
                errors++;
                $display("FAIL %s model: act m=%h n=%h t=%h so=%b exp m=%h n=%h t=%h so=%b",
                         phase, m_out, n_out, t_out, ser_out, mm, mn, mt, msr[13]);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b; wclk(4);
        ser_clk = 1'b1; wclk(4);
        ser_clk = 1'b0; wclk(4);
    endtask

    task automatic send_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_ser_strobe();
        ser_strobe = 1'b1; wclk(6);
        ser_strobe = 1'b0; wclk(6);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: act hung exp finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] w;
        wclk(4);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 m", 32'(m_out), 0);
        chk("R9 n", 32'(n_out), 0);
        chk("R9 t", 32'(t_out), 0);
        chk("R9 ser_out", 32'(ser_out), 0);

        // R3/R4 parallel transparency
        phase = "R3";
        par_m = 9'h1A5; par_n = 2'd2; wclk(6);
        chk("R3 m follows", 32'(m_out), 32'h1A5);
        chk("R3 n follows", 32'(n_out), 2);
        chk("R4 t zero", 32'(t_out), 0);

        // R8 latency: change on par_m appears on third edge
        phase = "R8";
        par_m = 9'h0C3;
        wclk(2);
        chk("R8 not yet", 32'(m_out), 32'h1A5);
        wclk(1);
        chk("R8 arrived", 32'(m_out), 32'h0C3);

        // R3 capture on rising strobe, later inputs ignored
        phase = "R3";
        par_strobe = 1'b1; wclk(6);
        par_m = 9'h033; par_n = 2'd1; wclk(8);
        chk("R3 m held", 32'(m_out), 32'h0C3);
        chk("R3 n held", 32'(n_out), 2);

        // R1/R2/R7: serial shift, outputs untouched until strobe
        phase = "R7";
        w = {3'b101, 2'b11, 9'h0F3};
        send_word(w);
        chk("R7 m unchanged", 32'(m_out), 32'h0C3);
        chk("R1 ser_out first bit", 32'(ser_out), 1);
        phase = "R2";
        pulse_ser_strobe();
        chk("R2 m field", 32'(m_out), 32'h0F3);
        chk("R2 n field", 32'(n_out), 3);
        chk("R2 t field", 32'(t_out), 5);

        // R5 transparency while serial strobe high, hold after fall
        phase = "R5";
        ser_strobe = 1'b1; wclk(6);
        shift_bit(1'b0);
        w = {w[12:0], 1'b0};
        chk("R5 follows sr", 32'({t_out, n_out, m_out}), 32'(w));
        ser_strobe = 1'b0; wclk(6);
        shift_bit(1'b1); shift_bit(1'b1);
        chk("R5 held after fall", 32'({t_out, n_out, m_out}), 32'(w));

        // R4/R6 parallel priority
        phase = "R6";
        par_strobe = 1'b0; par_m = 9'h111; par_n = 2'd0; wclk(6);
        chk("R4 t forced zero", 32'(t_out), 0);
        pulse_ser_strobe();
        chk("R6 m parallel", 32'(m_out), 32'h111);
        chk("R6 t zero", 32'(t_out), 0);
        par_strobe = 1'b1; wclk(6);
        chk("R4 t stays zero", 32'(t_out), 0);

        // R10 long serial clock high -> single shift
        phase = "R10";
        send_word(14'h3FFF);
        ser_data = 1'b0; wclk(4);
        ser_clk = 1'b1; wclk(30);
        ser_clk = 1'b0; wclk(4);
        pulse_ser_strobe();
        chk("R10 m", 32'(m_out), 32'h1FE);
        chk("R10 t", 32'(t_out), 7);
        chk("R1 ser_out", 32'(ser_out), 1);

        wclk(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule